// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block sits on the target side of a two-wire serial bus and decides whether a transfer is meant for it. It takes the raw clock and data lines, brings them into the local clock domain, and picks out start, repeated start and stop conditions. After each start it gathers the first byte, most significant bit first, and acknowledges it when the byte names this target, by pulling the data line low through an open-drain enable. It then raises a match flag together with the transfer direction.

The block can be built for standard 7-bit addressing or for extended 10-bit addressing. In 10-bit mode, a reserved first-byte prefix that carries the two upper address bits is acknowledged first. The following byte is then compared with the low eight bits of the address, and the second acknowledge is given only when that byte matches. Data bytes, clock stretching and arbitration are handled elsewhere. Once a match is reported, the block stays quiet until the bus is released.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, and with both lines held high, `sda_oe` and `match` are 0.
- R2: A start condition (data falling while the clock is high) begins capture of a new byte. Bits are sampled on clock rising edges, most significant bit first.
- R3: In 7-bit mode, a first byte whose bits 7:1 equal `OWN_ADDR7` is acknowledged. `sda_oe` rises after the clock falls following the eighth bit, stays high through the whole ninth clock pulse, and drops after that ninth pulse falls. `match` is then 1.
- R4: In 7-bit mode, any other first byte, including one of the form 11110xxx, gets no acknowledge, and `match` stays 0.
- R5: In 10-bit mode, a first byte equal to 11110, then `OWN_ADDR10[9:8]`, then the direction bit, is acknowledged with the same timing as R3. Any other first byte is not acknowledged.
- R6: In 10-bit mode, after an acknowledged prefix, a second byte equal to `OWN_ADDR10[7:0]` is acknowledged and sets `match`. Any other second byte gets no acknowledge and leaves `match` at 0.
- R7: When `match` is 1, `match_rd` equals bit 0 of the first byte after the start (1 means read, 0 means write). This holds in both modes.
- R8: After a match, later bytes in the same transfer are not acknowledged, and `match` holds until a stop or a start.
- R9: A stop condition (data rising while the clock is high) clears `match` and returns the block to idle.
- R10: A repeated start in the middle of a byte discards the partial bits. Capture restarts at the first address bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| match | output | 1 | This target has been addressed |
| match_rd | output | 1 | Direction of the matched transfer, 1 = read |

## Verification
The bench puts two instances on one shared open-drain bus, both with a two-stage synchronizer. `u0` is in 7-bit mode with address 0x3A, and `u1` is in 10-bit mode with address 0x2C5, so its prefix byte is 0xF4 or 0xF5. Every transfer therefore exercises both modes at once. A 10-bit prefix reaches the 7-bit instance as a non-matching address, and second bytes reach an instance that has already matched or is ignoring the transfer. The reserved prefix, the partial-byte repeated start and second-byte misses are driven directly. Random first and second bytes, weighted towards the two addresses, cover the rest.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR1 = 3'd1,
    ST_ACK1  = 3'd2,
    ST_ADDR2 = 3'd3,
    ST_ACK2  = 3'd4,
    ST_HIT   = 3'd5,
    ST_SKIP  = 3'd6
  } am_state_t;

  localparam logic [4:0] EXT_PREFIX = 5'b11110;
  localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[gi] <= '1;
        end else begin
          if (gi == 0) stg_q[gi] <= d;
          else         stg_q[gi] <= stg_q[(gi == 0) ? 0 : gi-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/i2c_am_evt.sv
module i2c_am_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic rise_ev,
  output logic fall_ev,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    rise_ev  =  scl_s & ~scl_q;
    fall_ev  = ~scl_s &  scl_q;
    start_ev =  scl_s &  scl_q &  sda_q & ~sda_s;
    stop_ev  =  scl_s &  scl_q & ~sda_q &  sda_s;
  end

endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
  import i2c_am_pkg::*;
#(
  parameter bit         TEN_BIT = 1'b0,
  parameter logic [6:0] OWN7    = 7'h3A,
  parameter logic [9:0] OWN10   = 10'h2C5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic rise_ev,
  input  logic fall_ev,
  input  logic start_ev,
  input  logic stop_ev,
  output logic sda_oe,
  output logic match,
  output logic match_rd
);

  localparam int unsigned CW = $clog2(BYTE_BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_BITS);
  localparam logic [6:0] PREFIX_HI = {EXT_PREFIX, OWN10[9:8]};

  am_state_t     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    sh_q, sh_d;
  logic          rw_q, rw_d;
  logic          match_q, match_d;
  logic          first_hit;

  always_comb begin
    if (TEN_BIT) first_hit = (sh_q[7:1] == PREFIX_HI);
    else         first_hit = (sh_q[7:1] == OWN7);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    match_d = match_q;
    if (stop_ev) begin
      state_d = ST_IDLE;
      match_d = 1'b0;
    end else if (start_ev) begin
      state_d = ST_ADDR1;
      cnt_d   = '0;
      sh_d    = '0;
      match_d = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR1, ST_ADDR2: begin
          if (rise_ev && cnt_q < FULL) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (fall_ev && cnt_q == FULL) begin
            if (state_q == ST_ADDR1) begin
              rw_d    = sh_q[0];
              state_d = first_hit ? ST_ACK1 : ST_SKIP;
            end else begin
              state_d = (sh_q == OWN10[7:0]) ? ST_ACK2 : ST_SKIP;
            end
          end
        end
        ST_ACK1: begin
          if (fall_ev) begin
            if (TEN_BIT) begin
              state_d = ST_ADDR2;
              cnt_d   = '0;
              sh_d    = '0;
            end else begin
              state_d = ST_HIT;
              match_d = 1'b1;
            end
          end
        end
        ST_ACK2: begin
          if (fall_ev) begin
            state_d = ST_HIT;
            match_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      match_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      match_q <= match_d;
    end
  end

  assign sda_oe   = (state_q == ST_ACK1) || (state_q == ST_ACK2);
  assign match    = match_q;
  assign match_rd = rw_q;

  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(fall_ev || start_ev || stop_ev)); // R3
  AST_MATCH_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match) |-> $past(sda_oe)); // R6
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !match); // R9
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (match && $past(match)) |-> $stable(match_rd)); // R7
  AST_NO_ACK_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !start_ev && !stop_ev) |=> !sda_oe); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL); // R2

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          ADDR_10B    = 1'b0,
  parameter logic [6:0]  OWN_ADDR7   = 7'h3A,
  parameter logic [9:0]  OWN_ADDR10  = 10'h2C5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe,
  output logic match,
  output logic match_rd
);

  logic rst_meta, rst_sync;
  logic scl_s, sda_s;
  logic rise_ev, fall_ev, start_ev, stop_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  i2c_am_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync),
    .d     ({scl_in, sda_in}),
    .q     ({scl_s, sda_s})
  );

  i2c_am_evt u_evt (
    .clk      (clk),
    .rst_n    (rst_sync),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_am_ctrl #(.TEN_BIT(ADDR_10B), .OWN7(OWN_ADDR7), .OWN10(OWN_ADDR10)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync),
    .sda_s    (sda_s),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_oe   (sda_oe),
    .match    (match),
    .match_rd (match_rd)
  );

endmodule

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;

  localparam int Q = 6;
  localparam logic [6:0] A7  = 7'h3A;
  localparam logic [9:0] A10 = 10'h2C5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic oe0, oe1, mt0, mt1, rd0, rd1;
  logic sda_line;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~oe0 & ~oe1;

  i2c_addr_match #(.SYNC_STAGES(2), .ADDR_10B(1'b0), .OWN_ADDR7(A7), .OWN_ADDR10(A10)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(oe0), .match(mt0), .match_rd(rd0));

  i2c_addr_match #(.SYNC_STAGES(2), .ADDR_10B(1'b1), .OWN_ADDR7(A7), .OWN_ADDR10(A10)) u1 (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(oe1), .match(mt1), .match_rd(rd1));

  function automatic bit hit7(input logic [7:0] b);
    return b[7:1] == A7;
  endfunction

  function automatic bit hit_pfx(input logic [7:0] b);
    return b[7:1] == {5'b11110, A10[9:8]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wq(Q);
      m_scl = 1'b1; wq(Q);
      if (i == 0) chk("R3 no early ack", int'(oe0 | oe1), 0);
      wq(Q);
      m_scl = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit e0, input bit e1, input string tag);
    send_bits(b, 8);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    chk({tag, " ack u0"}, int'(oe0), int'(e0));
    chk({tag, " ack u1"}, int'(oe1), int'(e1));
    wq(Q);
    m_scl = 1'b0; wq(Q);
    chk("R3 ack released", int'(oe0 | oe1), 0);
  endtask

  task automatic txn(input logic [7:0] b1, input logic [7:0] b2);
    bit e7, ep, e10;
    e7  = hit7(b1);
    ep  = hit_pfx(b1);
    e10 = ep && (b2 == A10[7:0]);
    do_start();
    send_byte(b1, e7, ep, "R3 R4 R5 first byte");
    chk("R3 R4 match u0", int'(mt0), int'(e7));
    if (e7) chk("R7 dir u0", int'(rd0), int'(b1[0]));
    send_byte(b2, 1'b0, e10, "R6 R8 second byte");
    chk("R6 match u1", int'(mt1), int'(e10));
    if (e10) chk("R7 dir u1", int'(rd1), int'(b1[0]));
    chk("R8 match held u0", int'(mt0), int'(e7));
    do_stop();
    wq(Q);
    chk("R9 stop clears", int'(mt0 | mt1), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b1, b2;
    void'($urandom(32'd4711));
    wq(4);
    rst_n = 1'b1;
    wq(8);
    chk("R1 reset oe", int'(oe0 | oe1), 0);
    chk("R1 reset match", int'(mt0 | mt1), 0);

    txn({A7, 1'b0}, 8'h55);
    txn({A7, 1'b1}, 8'h00);
    txn({A7 ^ 7'h01, 1'b0}, 8'h12);
    txn({5'b11110, A10[9:8], 1'b0}, A10[7:0]);
    txn({5'b11110, A10[9:8], 1'b1}, A10[7:0]);
    txn({5'b11110, A10[9:8], 1'b0}, A10[7:0] ^ 8'h80);
    txn({5'b11110, ~A10[9:8], 1'b0}, A10[7:0]);

    // R10: partial byte, then repeated start and a full matching address
    do_start();
    send_bits(8'hFF, 3);
    do_start();
    send_byte({A7, 1'b1}, 1'b1, 1'b0, "R10 restart");
    chk("R10 match", int'(mt0), 1);
    chk("R10 dir", int'(rd0), 1);
    do_stop();
    wq(Q);
    chk("R9 stop after restart", int'(mt0), 0);

    for (int k = 0; k < 40; k++) begin
      case ($urandom % 4)
        0: b1 = {A7, 1'($urandom)};
        1: b1 = {5'b11110, A10[9:8], 1'($urandom)};
        default: b1 = 8'($urandom);
      endcase
      b2 = ($urandom % 2 == 0) ? A10[7:0] : 8'($urandom);
      txn(b1, b2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule